// File: doc/BRIEF.md
# Display Register Window Decoder

This block sits behind a 4 KiB memory-mapped slave port of a display controller and turns each 32-bit request into accesses on two downstream register ports. Three windows are decoded. A 32-byte window at 0x400 reaches the byte-wide legacy port bus, where window offset A maps to port 0x3C0 + A. A 256-byte window at 0x500 reaches a 16-bit indexed mode register file: each 16-bit half first loads an index and then reads or writes the data register. An 8-byte extension window at 0x600 holds a size register and a framebuffer byte-order register.

The request stays valid and stable until `req_ready` is high for one cycle. Byte strobes give the width. Accesses wider than the downstream port are split into ordered single operations, lowest address first. Because the low byte goes first, a 16-bit write can load an index port and its data port in one bus access. The extension window exists only while the `ext_en` strap is high. The strap also selects the revision value that is exported.

Top module: `mmio_regwin`

## Requirements
- R1: A legacy access at word offset W with strobe lane i drives `lp_addr` = 0x3C0 + W + i. A read takes `lp_rdata` into bits 8i+7:8i of the response.
- R2: A legacy write with several strobes issues one byte write per cycle, in ascending lane order. The lowest lane is always issued first, and every enabled lane is issued exactly once.
- R3: A legacy read with several strobes returns each enabled port byte in its own lane. Lanes that are not enabled read zero.
- R4: In the mode window, each 16-bit half whose strobes are not all zero is handled as two cycles. The first cycle writes the index, equal to the window offset of that half shifted right by one. The second cycle writes or reads the data register. The low half goes first.
- R5: A mode read returns the data register value of each enabled half in that half. A disabled half reads zero.
- R6: With the extension enabled, a full-word read at 0x600 returns 8, the window size.
- R7: A full-word write of 0xBEBEBEBE at 0x604 sets `be_flag`, and 0x1E1E1E1E clears it. Any other value leaves it unchanged. A read at 0x604 returns the code that matches `be_flag`.
- R8: An extension access without all four strobes set reads zero and does not change `be_flag`.
- R9: While `ext_en` is low, the extension offsets read zero and ignore writes, and `rev_id` is BASE_REV. While `ext_en` is high, `rev_id` is 2.
- R10: Offsets outside the three windows read zero. They cause no downstream strobe.
- R11: After reset `be_flag` is 0 (little-endian), `req_ready` is low, and no downstream strobe is active.
- R12: `req_ready` rises n+1 cycles after a request is accepted when n legacy bytes are issued, and 2h+1 cycles after when h mode halves are issued. It rises 1 cycle after for every other request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_en | input | 1 | Strap enabling the extension window |
| req_valid | input | 1 | Request valid, held until ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset in the window (bits 1:0 ignored) |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobes |
| req_ready | output | 1 | Request complete, response valid |
| req_rdata | output | 32 | Read data, valid with req_ready |
| lp_valid | output | 1 | Legacy port byte cycle |
| lp_write | output | 1 | Legacy cycle is a write |
| lp_addr | output | 10 | Legacy port address |
| lp_wdata | output | 8 | Legacy write byte |
| lp_rdata | input | 8 | Legacy read byte |
| mr_index_we | output | 1 | Mode index load |
| mr_index | output | 16 | Mode register index |
| mr_data_we | output | 1 | Mode data write |
| mr_data_re | output | 1 | Mode data read |
| mr_wdata | output | 16 | Mode write data |
| mr_rdata | input | 16 | Mode read data |
| be_flag | output | 1 | Big-endian framebuffer flag |
| rev_id | output | 8 | Exported revision value |

## Verification
Random strobe masks on both the legacy and mode windows exercise the gaps between lanes. Non-adjacent lanes show whether splitting skips disabled bytes and keeps ascending order. Masks that touch only one half show whether half selection and index arithmetic are independent. Byte-order writes mix the two codes with near-miss values, partial strobes and a disabled strap, which separates a flag that follows magic codes from one that follows any write. Reads of offsets just past each window edge confirm that decoding stops there.

// File: rtl/mmio_regwin.sv
module mmio_regwin #(
  parameter logic [7:0]  BASE_REV = 8'h01,
  parameter logic [31:0] BE_CODE  = 32'hBEBE_BEBE,
  parameter logic [31:0] LE_CODE  = 32'h1E1E_1E1E
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ext_en,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_strb,
  output logic        req_ready,
  output logic [31:0] req_rdata,
  output logic        lp_valid,
  output logic        lp_write,
  output logic [9:0]  lp_addr,
  output logic [7:0]  lp_wdata,
  input  logic [7:0]  lp_rdata,
  output logic        mr_index_we,
  output logic [15:0] mr_index,
  output logic        mr_data_we,
  output logic        mr_data_re,
  output logic [15:0] mr_wdata,
  input  logic [15:0] mr_rdata,
  output logic        be_flag,
  output logic [7:0]  rev_id
);
  localparam logic [9:0]  PORT_BASE = 10'h3C0;
  localparam logic [31:0] EXT_SIZE  = 32'd8;

  typedef enum logic [1:0] {ST_IDLE, ST_LEG, ST_MODE, ST_DONE} st_t;

  st_t         st;
  logic [3:0]  pend;
  logic        phase;
  logic [31:0] rbuf;
  logic        be_q;
  logic [1:0]  lane;
  logic        hsel;
  logic [3:0]  pend_lane_nxt;
  logic [3:0]  pend_half_nxt;
  logic        unused_addr;

  assign unused_addr = ^req_addr[1:0];

  wire hit_leg  = req_addr[11:5] == 7'h20;
  wire hit_mode = req_addr[11:8] == 4'h5;
  wire hit_ext  = ext_en && (req_addr[11:3] == 9'h0C0);
  wire ext_full = req_strb == 4'hF;
  wire [31:0] ext_rd = !(hit_ext && ext_full) ? 32'd0 :
                       req_addr[2] ? (be_q ? BE_CODE : LE_CODE) : EXT_SIZE;

  always_comb begin
    lane = 2'd0;
    for (int i = 3; i >= 0; i--)
      if (pend[i]) lane = i[1:0];
  end

  assign hsel          = !pend[0];
  assign pend_lane_nxt = pend & ~(4'b0001 << lane);
  assign pend_half_nxt = pend & ~(hsel ? 4'b0010 : 4'b0001);

  assign lp_valid    = st == ST_LEG;
  assign lp_write    = req_write;
  assign lp_addr     = PORT_BASE + {5'd0, req_addr[4:2], lane};
  assign lp_wdata    = req_wdata[{lane, 3'b000} +: 8];
  assign mr_index_we = (st == ST_MODE) && !phase;
  assign mr_index    = {9'd0, req_addr[7:2], hsel};
  assign mr_data_we  = (st == ST_MODE) && phase && req_write;
  assign mr_data_re  = (st == ST_MODE) && phase && !req_write;
  assign mr_wdata    = req_wdata[{hsel, 4'b0000} +: 16];
  assign req_ready   = st == ST_DONE;
  assign req_rdata   = rbuf;
  assign be_flag     = be_q;
  assign rev_id      = ext_en ? 8'd2 : BASE_REV;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      pend  <= 4'd0;
      phase <= 1'b0;
      rbuf  <= 32'd0;
      be_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          rbuf  <= 32'd0;
          phase <= 1'b0;
          if (hit_leg && |req_strb) begin
            st   <= ST_LEG;
            pend <= req_strb;
          end else if (hit_mode && |req_strb) begin
            st   <= ST_MODE;
            pend <= {2'b00, |req_strb[3:2], |req_strb[1:0]};
          end else begin
            st   <= ST_DONE;
            rbuf <= req_write ? 32'd0 : ext_rd;
            if (hit_ext && ext_full && req_write && req_addr[2]) begin
              if (req_wdata == BE_CODE)      be_q <= 1'b1;
              else if (req_wdata == LE_CODE) be_q <= 1'b0;
            end
          end
        end
        ST_LEG: begin
          if (!req_write) rbuf[{lane, 3'b000} +: 8] <= lp_rdata;
          pend <= pend_lane_nxt;
          if (pend_lane_nxt == 4'd0) st <= ST_DONE;
        end
        ST_MODE: begin
          if (!phase) phase <= 1'b1;
          else begin
            phase <= 1'b0;
            if (!req_write) rbuf[{hsel, 4'b0000} +: 16] <= mr_rdata;
            pend <= pend_half_nxt;
            if (pend_half_nxt == 4'd0) st <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mmio_regwin_chk.sv
module mmio_regwin_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_write,
  input logic       req_ready,
  input logic       lp_valid,
  input logic [9:0] lp_addr,
  input logic       mr_index_we,
  input logic       mr_data_we,
  input logic       mr_data_re,
  input logic       be_flag
);
  a_r1_port_range: assert property (@(posedge clk) disable iff (!rst_n)
    lp_valid |-> (lp_addr >= 10'h3C0 && lp_addr <= 10'h3DF));

  a_r12_no_ready_mid_split: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_valid || mr_index_we || mr_data_we || mr_data_re) |-> !req_ready);

  a_r4_index_before_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_data_we || mr_data_re) |-> $past(mr_index_we));

  a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lp_valid, mr_index_we, mr_data_we, mr_data_re}));

  a_r11_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !(lp_valid || mr_index_we || mr_data_we || mr_data_re || req_ready));

  a_r7_flag_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(be_flag) |-> $past(req_valid && req_write));
endmodule

bind mmio_regwin mmio_regwin_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_ready(req_ready), .lp_valid(lp_valid), .lp_addr(lp_addr),
  .mr_index_we(mr_index_we), .mr_data_we(mr_data_we), .mr_data_re(mr_data_re),
  .be_flag(be_flag)
);

// File: tb/mmio_regwin_tb.sv
module mmio_regwin_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BE_MAGIC = 32'hBEBE_BEBE;
  localparam logic [31:0] LE_MAGIC = 32'h1E1E_1E1E;
  localparam logic [7:0]  REV_BASE = 8'h01;

  logic clk = 0, rst_n = 0, ext_en = 1;
  logic req_valid = 0, req_write = 0;
  logic [11:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0]  req_strb = 0;
  logic req_ready;
  logic [31:0] req_rdata;
  logic lp_valid, lp_write;
  logic [9:0] lp_addr;
  logic [7:0] lp_wdata, lp_rdata;
  logic mr_index_we, mr_data_we, mr_data_re;
  logic [15:0] mr_index, mr_wdata, mr_rdata;
  logic be_flag;
  logic [7:0] rev_id;

  always #(CLK_PERIOD/2) clk = ~clk;

  mmio_regwin u_dut (.*);

  logic [7:0]  lmem [0:31];
  logic [15:0] mmem [0:127];
  logic [6:0]  bidx = 0;
  logic [31:0] ev [0:15];
  int ev_n = 0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic exp_be = 0;

  assign lp_rdata = lmem[lp_addr[4:0]];
  assign mr_rdata = mmem[bidx];

  task automatic logev(input logic [31:0] x);
    if (ev_n < 16) ev[ev_n] = x;
    ev_n++;
  endtask

  always @(negedge clk) if (rst_n) begin
    if (lp_valid) begin
      logev({8'h01, 6'd0, lp_addr, lp_write ? lp_wdata : 8'h00});
      if (lp_write) lmem[lp_addr[4:0]] = lp_wdata;
    end
    if (mr_index_we) begin logev({8'h02, 8'h00, mr_index}); bidx = mr_index[6:0]; end
    if (mr_data_we) begin logev({8'h03, 8'h00, mr_wdata}); mmem[bidx] = mr_wdata; end
    if (mr_data_re) logev({8'h04, 24'h0});
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", cyc, 0);
      finish_run();
    end
  end

  task automatic run_txn(input bit w, input logic [11:0] addr, input logic [31:0] data,
                         input logic [3:0] strb);
    logic [31:0] exp_ev [0:15];
    int exp_n = 0, lat = 0, exp_lat = 1, n = 0;
    logic [31:0] exp_rd = 0, rd;
    string tg;
    logic [11:0] off = {addr[11:2], 2'b00};
    tg = "R10";
    if (off[11:5] == 7'h20) begin
      tg = w ? "R2" : "R3";
      for (int i = 0; i < 4; i++) if (strb[i]) begin
        logic [4:0] a = off[4:0] + 5'(i);
        exp_ev[exp_n++] = {8'h01, 6'd0, 10'h3C0 + {5'd0, a}, w ? data[8*i +: 8] : 8'h00};
        if (!w) exp_rd[8*i +: 8] = lmem[a];
        n++;
      end
      exp_lat = n + 1;
    end else if (off[11:8] == 4'h5) begin
      tg = w ? "R4" : "R5";
      for (int h = 0; h < 2; h++) if (strb[2*h +: 2] != 2'b00) begin
        logic [6:0] ix = {off[7:2], h[0]};
        exp_ev[exp_n++] = {8'h02, 8'h00, 9'd0, ix};
        exp_ev[exp_n++] = w ? {8'h03, 8'h00, data[16*h +: 16]} : {8'h04, 24'h0};
        if (!w) exp_rd[16*h +: 16] = mmem[ix];
        n++;
      end
      exp_lat = 2*n + 1;
    end else if (ext_en && off[11:3] == 9'h0C0) begin
      if (strb != 4'hF) tg = "R8";
      else if (off[2]) begin
        tg = "R7";
        if (w && data == BE_MAGIC) exp_be = 1;
        else if (w && data == LE_MAGIC) exp_be = 0;
        exp_rd = exp_be ? BE_MAGIC : LE_MAGIC;
      end else begin
        tg = "R6";
        exp_rd = 32'd8;
      end
      if (w) exp_rd = 0;
    end else if (off[11:3] == 9'h0C0) tg = "R9";
    @(negedge clk);
    ev_n = 0;
    req_valid = 1; req_write = w; req_addr = addr; req_wdata = data; req_strb = strb;
    do begin
      @(posedge clk); #1; lat++;
    end while (!req_ready && lat < 60);
    rd = req_rdata;
    @(posedge clk); #1;
    req_valid = 0;
    chk(lat == exp_lat, "R12 latency", lat, exp_lat);
    if (!w) chk(rd == exp_rd, tg, rd, exp_rd);
    chk(ev_n == exp_n, {tg, " downstream count"}, ev_n, exp_n);
    for (int k = 0; k < exp_n && k < ev_n && k < 16; k++)
      chk(ev[k] == exp_ev[k], (off[11:5] == 7'h20) ? {tg, " R1 port order"} : {tg, " order"},
          ev[k], exp_ev[k]);
    chk(be_flag == exp_be, {tg, " flag"}, be_flag, exp_be);
    chk(rev_id == (ext_en ? 8'd2 : REV_BASE), "R9 rev", rev_id, ext_en ? 8'd2 : REV_BASE);
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 32; i++) lmem[i] = 8'($urandom);
    for (int i = 0; i < 128; i++) mmem[i] = 16'($urandom);
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready == 0, "R11 ready", req_ready, 0);
    chk(be_flag == 0, "R11 flag", be_flag, 0);
    chk(!lp_valid && !mr_index_we && !mr_data_we && !mr_data_re, "R11 strobes",
        {lp_valid, mr_index_we, mr_data_we, mr_data_re}, 0);
    @(negedge clk); rst_n = 1;

    run_txn(1, 12'h414, 32'h0000_A55A, 4'b0011);
    run_txn(0, 12'h414, 0, 4'b0011);
    run_txn(1, 12'h41C, 32'h1122_3344, 4'b1001);
    run_txn(0, 12'h400, 0, 4'b1111);
    run_txn(1, 12'h508, 32'hBEEF_0123, 4'b1100);
    run_txn(0, 12'h508, 0, 4'b1111);
    run_txn(0, 12'h600, 0, 4'hF);
    run_txn(1, 12'h604, BE_MAGIC, 4'hF);
    run_txn(0, 12'h604, 0, 4'hF);
    run_txn(1, 12'h604, 32'hBEBE_BEBF, 4'hF);
    run_txn(1, 12'h604, LE_MAGIC, 4'b0111);
    run_txn(0, 12'h604, 0, 4'b0111);
    run_txn(1, 12'h604, LE_MAGIC, 4'hF);
    run_txn(0, 12'h420, 0, 4'hF);
    run_txn(0, 12'h608, 0, 4'hF);
    run_txn(0, 12'h4FC, 0, 4'hF);
    ext_en = 0;
    run_txn(1, 12'h604, BE_MAGIC, 4'hF);
    run_txn(0, 12'h600, 0, 4'hF);
    ext_en = 1;

    for (int t = 0; t < 600; t++) begin
      int r = $urandom % 5;
      bit w = 1'($urandom);
      logic [3:0] s = 4'($urandom);
      logic [31:0] d = $urandom;
      if (t % 97 == 50) ext_en = ~ext_en;
      case (r)
        0: run_txn(w, {7'h20, 5'($urandom)}, d, s);
        1: run_txn(w, {4'h5, 8'($urandom)}, d, s);
        2: begin
          int m = $urandom % 4;
          if (m == 0) d = BE_MAGIC; else if (m == 1) d = LE_MAGIC;
          run_txn(w, {9'h0C0, 1'($urandom), 2'b00}, d, ($urandom % 3 == 0) ? s : 4'hF);
        end
        3: begin
          logic [11:0] ua [0:5] = '{12'h000, 12'h3FC, 12'h420, 12'h608, 12'h700, 12'hFFC};
          run_txn(w, ua[$urandom % 6], d, s);
        end
        default: run_txn(w, {9'h0C0, 1'b1, 2'b00}, d, 4'hF);
      endcase
    end
    finish_run();
  end
endmodule